// File: doc/BRIEF.md
# Reset and Clock Startup Sequencer

This block brings a microcontroller-style system out of power-on reset, out of an external reset and out of low-power stop. It holds an internal system reset and runs a clock quality check on the oscillator with a timeout. It picks the crystal clock or an internal self clock, and it gates the clock enable that goes to the rest of the system. The check counts rising edges of the synchronized oscillator signal in fixed sampling windows. The check passes once a set number of consecutive windows each hold enough edges.

The check runs after power-on and after a wake from stop. An accepted external reset skips the check when the oscillator was seen running in the last sampling window before the reset. If the check times out, the system falls back to the self clock. A power-on flag records whether the last reset came from power-on, so software can tell whether memory contents survived. Software clears the flag by writing a one.

The power-on request asserts the internal reset at once and is released through a two-flop reset synchronizer. Every timing value is a parameter.

Top module: `rcs_seq`

## Requirements
- R1: While `por_req` is high: `sys_rst_n`=0, `clk_en`=0, `st_por_hold`=1 and `por_flag`=1.
- R2: After power-on release the block enters the check state with `osc_en`=1. The check passes once GOOD_WIN consecutive windows of WIN_LEN cycles each contain at least MIN_EDGES rising edges of `osc_in`. It then moves to startup with `clk_sel_self`=0.
- R3: A check that has not passed after CHECK_TMO cycles in the check state moves to the self-clock state with `clk_sel_self`=1. The next state is startup.
- R4: The startup state lasts exactly STARTUP_CYC cycles with `sys_rst_n`=0. The block then enters run with `sys_rst_n`=1 and `clk_en`=1.
- R5: `ext_rst_n` must be low for fewer than MIN_LOW synchronized cycles to be ignored. Such a pulse leaves the block in run with `sys_rst_n`=1.
- R6: `ext_rst_n` low for MIN_LOW or more synchronized cycles is accepted. The block enters the reset-hold state with `sys_rst_n`=0 while the pin stays low. On release it goes straight to startup if the last complete window held at least MIN_EDGES edges. Otherwise it goes to the check state.
- R7: `por_flag` is set only by power-on and is not changed by external resets. A cycle with `flag_wr`=1 and `flag_wdata`=1 clears it. `flag_wr`=1 with `flag_wdata`=0 leaves it unchanged.
- R8: `stop_req` in run enters stop with `clk_en`=0 and `osc_en`=0. The block stays in stop until `wake_irq`.
- R9: `wake_irq` in stop enters the wake-check state. `clk_en` stays 0 until the check passes, and the block then returns to run with `clk_sel_self`=0.
- R10: A wake check that has not passed after CHECK_TMO cycles returns to run with `clk_sel_self`=1.
- R11: Exactly one of the seven state outputs is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_req | input | 1 | Power-on reset request, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wake_irq | input | 1 | Wake interrupt, used in stop |
| stop_req | input | 1 | Request to enter stop, used in run |
| osc_in | input | 1 | Raw oscillator activity signal |
| flag_wr | input | 1 | Write strobe for the power-on flag |
| flag_wdata | input | 1 | Write data; a one clears the flag |
| sys_rst_n | output | 1 | Internal system reset, active low |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | System clock enable |
| clk_sel_self | output | 1 | 1 selects the self clock, 0 the oscillator |
| por_flag | output | 1 | Power-on flag read data |
| st_por_hold | output | 1 | State: reset hold |
| st_check | output | 1 | State: clock check after reset |
| st_self_clock | output | 1 | State: self-clock fallback |
| st_startup | output | 1 | State: startup count |
| st_run | output | 1 | State: run |
| st_stop | output | 1 | State: stop |
| st_wake_check | output | 1 | State: clock check after wake |

## Verification
The hardest case to reach is the external reset that finds no oscillator. The block skips the check only when the last sampling window was good, so the bench first stops the oscillator model and waits for several full windows to pass. It then holds the pin low, and after release the block must go back through the full check, the timeout and the self-clock path. The same idle oscillator drives the wake timeout. The bench measures the length of each timed state in cycles.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [2:0] {
    S_POR_HOLD  = 3'd0,
    S_CHECK     = 3'd1,
    S_SELF_CLK  = 3'd2,
    S_STARTUP   = 3'd3,
    S_RUN       = 3'd4,
    S_STOP      = 3'd5,
    S_WAKE_CHK  = 3'd6
  } rcs_state_e;

  // A sampling window is good when it held at least min_e rising edges.
  function automatic logic window_good(input int unsigned edges, input int unsigned min_e);
    return edges >= min_e;
  endfunction

  // The count reached its last cycle (a state of n cycles ends at n-1).
  function automatic logic at_last(input int unsigned cnt, input int unsigned n);
    return cnt == n - 1;
  endfunction
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rcs_osc_check.sv
module rcs_osc_check #(
  parameter int WIN_LEN   = 16,
  parameter int MIN_EDGES = 3,
  parameter int GOOD_WIN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_s,
  input  logic en,
  output logic pass,
  output logic alive
);
  import rcs_pkg::*;
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int GW = $clog2(GOOD_WIN + 1);

  logic          osc_d;
  logic [WW-1:0] win_cnt, edge_cnt;
  logic [GW-1:0] good_cnt;
  logic          rise, win_end, win_ok;

  assign rise    = osc_s & ~osc_d;
  assign win_end = at_last(int'(win_cnt), WIN_LEN);
  assign win_ok  = window_good(int'(edge_cnt) + int'(rise), MIN_EDGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_d    <= 1'b0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      good_cnt <= '0;
      alive    <= 1'b0;
    end else begin
      osc_d <= osc_s;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
        alive    <= win_ok;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        edge_cnt <= edge_cnt + WW'(rise);
      end
      if (!en)
        good_cnt <= '0;
      else if (win_end)
        good_cnt <= !win_ok ? '0 :
                    (good_cnt == GW'(GOOD_WIN)) ? good_cnt : good_cnt + 1'b1;
    end
  end

  assign pass = en && (good_cnt == GW'(GOOD_WIN));
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq #(
  parameter int WIN_LEN     = 16,
  parameter int MIN_EDGES   = 3,
  parameter int GOOD_WIN    = 2,
  parameter int CHECK_TMO   = 200,
  parameter int STARTUP_CYC = 192,
  parameter int MIN_LOW     = 2
) (
  input  logic clk,
  input  logic por_req,
  input  logic ext_rst_n,
  input  logic wake_irq,
  input  logic stop_req,
  input  logic osc_in,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic sys_rst_n,
  output logic osc_en,
  output logic clk_en,
  output logic clk_sel_self,
  output logic por_flag,
  output logic st_por_hold,
  output logic st_check,
  output logic st_self_clock,
  output logic st_startup,
  output logic st_run,
  output logic st_stop,
  output logic st_wake_check
);
  import rcs_pkg::*;
  localparam int TW = $clog2(CHECK_TMO + 1);
  localparam int SW = $clog2(STARTUP_CYC + 1);
  localparam int LW = $clog2(MIN_LOW + 1);

  // Power-on reset: asynchronous assertion, synchronous release.
  logic [1:0] por_sync;
  logic       rst_n;
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) por_sync <= 2'b00;
    else         por_sync <= {por_sync[0], 1'b1};
  end
  assign rst_n = por_sync[1];

  logic pin_s, osc_s;
  rcs_sync #(.STAGES(2), .RST_VAL(1'b1)) i_pin_sync (.clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(pin_s));
  rcs_sync #(.STAGES(2), .RST_VAL(1'b0)) i_osc_sync (.clk(clk), .rst_n(rst_n), .d(osc_in),    .q(osc_s));

  // External reset pulse-width qualification.
  logic [LW-1:0] low_cnt;
  logic          ext_hit, ext_hold;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= '0;
    else if (pin_s)                  low_cnt <= '0;
    else if (low_cnt != LW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
  end
  assign ext_hit  = !pin_s && (int'(low_cnt) == MIN_LOW - 1);
  assign ext_hold = !pin_s && (int'(low_cnt) >= MIN_LOW - 1);

  rcs_state_e    state, nxt;
  logic          chk_en, chk_pass, osc_alive, tmo_hit, su_done, skip_q;
  logic [TW-1:0] tmo_cnt;
  logic [SW-1:0] su_cnt;

  assign chk_en = (state == S_CHECK) || (state == S_WAKE_CHK);

  rcs_osc_check #(.WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES), .GOOD_WIN(GOOD_WIN)) i_chk (
    .clk(clk), .rst_n(rst_n), .osc_s(osc_s), .en(chk_en), .pass(chk_pass), .alive(osc_alive));

  assign tmo_hit = chk_en && !chk_pass && at_last(int'(tmo_cnt), CHECK_TMO);
  assign su_done = (state == S_STARTUP) && at_last(int'(su_cnt), STARTUP_CYC);

  always_comb begin
    nxt = state;
    unique case (state)
      S_POR_HOLD: if (!ext_hold) nxt = skip_q ? S_STARTUP : S_CHECK;
      S_CHECK:    if (chk_pass) nxt = S_STARTUP; else if (tmo_hit) nxt = S_SELF_CLK;
      S_SELF_CLK: nxt = S_STARTUP;
      S_STARTUP:  if (su_done) nxt = S_RUN;
      S_RUN:      if (stop_req) nxt = S_STOP;
      S_STOP:     if (wake_irq) nxt = S_WAKE_CHK;
      S_WAKE_CHK: if (chk_pass || tmo_hit) nxt = S_RUN;
      default:    nxt = S_POR_HOLD;
    endcase
    if (ext_hit) nxt = S_POR_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_POR_HOLD;
      tmo_cnt      <= '0;
      su_cnt       <= '0;
      skip_q       <= 1'b0;
      clk_sel_self <= 1'b0;
      sys_rst_n    <= 1'b0;
      por_flag     <= 1'b1;
    end else begin
      state     <= nxt;
      sys_rst_n <= (nxt == S_RUN);
      tmo_cnt   <= (chk_en && nxt == state) ? tmo_cnt + 1'b1 : '0;
      su_cnt    <= (state == S_STARTUP && nxt == state) ? su_cnt + 1'b1 : '0;
      if (ext_hit)       skip_q <= osc_alive;
      if (chk_pass)      clk_sel_self <= 1'b0;
      else if (tmo_hit)  clk_sel_self <= 1'b1;
      if (flag_wr && flag_wdata) por_flag <= 1'b0;
    end
  end

  assign st_por_hold   = (state == S_POR_HOLD);
  assign st_check      = (state == S_CHECK);
  assign st_self_clock = (state == S_SELF_CLK);
  assign st_startup    = (state == S_STARTUP);
  assign st_run        = (state == S_RUN);
  assign st_stop       = (state == S_STOP);
  assign st_wake_check = (state == S_WAKE_CHK);
  assign osc_en        = (state != S_STOP);
  assign clk_en        = st_self_clock || st_startup || st_run;
endmodule

// File: rtl/rcs_seq_chk.sv
module rcs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_hit,
  input logic tmo_hit,
  input logic chk_pass,
  input logic skip_q,
  input logic por_flag,
  input logic clk_sel_self,
  input logic st_por_hold,
  input logic st_check,
  input logic st_self_clock,
  input logic st_startup,
  input logic st_run,
  input logic st_stop,
  input logic st_wake_check
);
  // R7: the flag never rises outside power-on reset
  assert_flag_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !por_flag |=> !por_flag);

  // R5: run is left for reset hold only through a qualified pin event
  assert_short_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_run && !ext_hit |=> !st_por_hold);

  // R6: a direct jump from hold to startup needs the oscillator seen alive
  assert_skip_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_por_hold) && st_startup |-> $past(skip_q));

  // R3: self clock is entered only after a timeout
  assert_self_after_tmo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_self_clock |-> $past(tmo_hit));

  // R9: wake returns to run on the oscillator only after a passed check
  assert_wake_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_wake_check) && st_run && !clk_sel_self |-> $past(chk_pass));

  // R8: stop is held until a wake or a qualified reset
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_stop |=> st_stop || st_wake_check || st_por_hold);

  // R11: one state output at a time
  assert_one_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_por_hold, st_check, st_self_clock, st_startup, st_run, st_stop, st_wake_check}));
endmodule

bind rcs_seq rcs_seq_chk i_rcs_seq_chk (
  .clk(clk), .rst_n(rst_n), .ext_hit(ext_hit), .tmo_hit(tmo_hit), .chk_pass(chk_pass),
  .skip_q(skip_q), .por_flag(por_flag), .clk_sel_self(clk_sel_self),
  .st_por_hold(st_por_hold), .st_check(st_check), .st_self_clock(st_self_clock),
  .st_startup(st_startup), .st_run(st_run), .st_stop(st_stop), .st_wake_check(st_wake_check));

// File: tb/test_rcs_seq.sv
module test_rcs_seq;
  localparam int WIN = 16, MINE = 3, GW = 2, TMO = 100, SC = 40, ML = 2;

  logic clk = 1'b0;
  logic por_req = 1'b1, ext_rst_n = 1'b1, wake_irq = 1'b0, stop_req = 1'b0;
  logic osc_in = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0, osc_on = 1'b0;
  logic sys_rst_n, osc_en, clk_en, clk_sel_self, por_flag;
  logic st_por_hold, st_check, st_self_clock, st_startup, st_run, st_stop, st_wake_check;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rcs_seq #(.WIN_LEN(WIN), .MIN_EDGES(MINE), .GOOD_WIN(GW), .CHECK_TMO(TMO),
            .STARTUP_CYC(SC), .MIN_LOW(ML)) i_rcs_seq (
    .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wake_irq(wake_irq),
    .stop_req(stop_req), .osc_in(osc_in), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .sys_rst_n(sys_rst_n), .osc_en(osc_en), .clk_en(clk_en), .clk_sel_self(clk_sel_self),
    .por_flag(por_flag), .st_por_hold(st_por_hold), .st_check(st_check),
    .st_self_clock(st_self_clock), .st_startup(st_startup), .st_run(st_run),
    .st_stop(st_stop), .st_wake_check(st_wake_check));

  // Oscillator model: period of four sequencer cycles while enabled.
  initial forever begin
    repeat (2) @(posedge clk);
    #3 if (osc_on) osc_in = ~osc_in;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next falling edge until the given state output is high.
  task automatic wait_state(input int idx, input int maxc, input string req);
    int n = 0;
    logic [6:0] st;
    forever begin
      st = {st_wake_check, st_stop, st_run, st_startup, st_self_clock, st_check, st_por_hold};
      if (st[idx] || n >= maxc) break;
      @(negedge clk); n++;
    end
    check({req, " reached state"}, int'(st[idx]), 1);
  endtask

  task automatic count_state(input int idx, output int n);
    logic [6:0] st;
    n = 0;
    forever begin
      st = {st_wake_check, st_stop, st_run, st_startup, st_self_clock, st_check, st_por_hold};
      if (!st[idx] || n > 10000) break;
      @(negedge clk); n++;
    end
  endtask

  task automatic check_onehot();
    check("R11 one state output", $countones({st_wake_check, st_stop, st_run, st_startup,
          st_self_clock, st_check, st_por_hold}), 1);
  endtask

  task automatic t_reset();
    por_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sys_rst_n", sys_rst_n, 0);
    check("R1 clk_en", clk_en, 0);
    check("R1 st_por_hold", st_por_hold, 1);
    check("R1 por_flag", por_flag, 1);
    check_onehot();
  endtask

  task automatic t_boot_dead();
    int n;
    por_req = 1'b0;
    wait_state(1, 10, "R2 check after release");
    check("R2 osc_en", osc_en, 1);
    count_state(1, n);
    check("R3 check timeout length", n, TMO);
    check("R3 self clock state", st_self_clock, 1);
    check("R3 clk_sel_self", clk_sel_self, 1);
    @(negedge clk);
    check("R3 startup after self clock", st_startup, 1);
    wait_state(4, SC + 5, "R3 run");
    check("R3 run on self clock", clk_sel_self, 1);
  endtask

  task automatic t_boot_osc();
    int n;
    osc_on = 1'b1;
    por_req = 1'b1;
    repeat (2) @(negedge clk);
    por_req = 1'b0;
    wait_state(1, 10, "R2 check");
    wait_state(3, TMO, "R2 pass to startup");
    check("R2 oscillator selected", clk_sel_self, 0);
    check("R4 reset held in startup", sys_rst_n, 0);
    count_state(3, n);
    check("R4 startup length", n, SC);
    check("R4 run", st_run, 1);
    check("R4 sys_rst_n released", sys_rst_n, 1);
    check("R4 clk_en", clk_en, 1);
    check_onehot();
  endtask

  task automatic t_flag();
    flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    @(negedge clk);
    check("R7 write zero keeps flag", por_flag, 1);
    flag_wr = 1'b1; flag_wdata = 1'b1;
    @(negedge clk); flag_wr = 1'b0; flag_wdata = 1'b0;
    @(negedge clk);
    check("R7 write one clears flag", por_flag, 0);
  endtask

  task automatic t_short_pulse();
    ext_rst_n = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R5 short pulse stays in run", st_run, 1);
    check("R5 short pulse sys_rst_n", sys_rst_n, 1);
  endtask

  task automatic t_ext_alive();
    int n;
    ext_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 hold while pin low", st_por_hold, 1);
    check("R6 sys_rst_n low", sys_rst_n, 0);
    ext_rst_n = 1'b1;
    n = 0;
    while (st_por_hold && n < 10) begin @(negedge clk); n++; end
    check("R6 skip check to startup", st_startup, 1);
    wait_state(4, SC + 5, "R6 run");
    check("R7 flag unchanged by external reset", por_flag, 0);
  endtask

  task automatic t_stop_wake_ok();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    check("R8 stop", st_stop, 1);
    check("R8 clk_en off", clk_en, 0);
    check("R8 osc_en off", osc_en, 0);
    repeat (5) @(negedge clk);
    check("R8 stays in stop", st_stop, 1);
    wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
    check("R9 wake check", st_wake_check, 1);
    check("R9 clk_en held off", clk_en, 0);
    wait_state(4, TMO, "R9 back to run");
    check("R9 oscillator selected", clk_sel_self, 0);
    check("R9 clk_en on", clk_en, 1);
  endtask

  task automatic t_stop_wake_tmo();
    int n;
    osc_on = 1'b0;
    repeat (3 * WIN) @(negedge clk);
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
    count_state(6, n);
    check("R10 wake timeout length", n, TMO);
    check("R10 run", st_run, 1);
    check("R10 self clock selected", clk_sel_self, 1);
  endtask

  task automatic t_ext_dead();
    ext_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    ext_rst_n = 1'b1;
    wait_state(1, 10, "R6 check when oscillator idle");
    wait_state(2, TMO + 5, "R6 self clock fallback");
    wait_state(4, SC + 5, "R6 run");
    check("R6 run on self clock", clk_sel_self, 1);
    check_onehot();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_boot_dead();
    t_boot_osc();
    t_flag();
    t_short_pulse();
    t_ext_alive();
    t_stop_wake_ok();
    t_stop_wake_tmo();
    t_ext_dead();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule